// File: doc/BRIEF.md
# Banked data RAM window

This block is a byte-wide data-space memory with a 64-byte window at the bottom of the address map. One bank-select register, at data-space address CBh, steers the window to one of three physical pages. These are a base page and two extra pages. The CPU places the select value in that register with an ordinary byte write. It then addresses the banked storage at 00h–3Fh, as though the window were always page 0.

The select register can only be written. It has no reset, so a reset leaves its value unchanged, and software must load it before the first access to the window. The select bits are one-hot. If software sets both of them, both extra pages are enabled at once. In that state a write lands in each enabled page, a read returns the bitwise OR of the enabled pages, and an error flag stays high for as long as the condition lasts.

Top module: `bram_window`

## Requirements
- R1: A write with `we_i` high to address CBh loads the select register on the rising clock edge. Only bit 3 and bit 4 of the written byte are kept.
- R2: A read of address CBh returns 00h, whatever the select register holds.
- R3: When bits 4 and 3 of the register are both 0, window accesses at 00h–3Fh go to base page 0. The other register bits have no effect: writing 01h or E7h behaves the same as writing 00h.
- R4: With bit 3 set alone, the window maps to page 1. With bit 4 set alone, it maps to page 2. Each page keeps its own 64 bytes and is not disturbed by writes made while another page is selected.
- R5: Asserting `rst_ni` low does not change the select register or the page contents.
- R6: With bits 4 and 3 both set, a window write updates pages 1 and 2, and a window read returns the OR of the two bytes.
- R7: `multi_sel_o` is 1 exactly when both select bits are set, and 0 otherwise.
- R8: `rdata_o` is combinational. It shows the addressed window byte in the same cycle as `re_i`. It is 00h when `re_i` is low, and 00h for addresses 40h and above other than CBh. Writes to addresses 40h and above, other than CBh, change no page.
- R9: While `rst_ni` is low, writes are ignored. Neither the select register nor any page changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes take effect on its rising edge |
| rst_ni | input | 1 | Active-low reset; blocks writes while low |
| addr_i | input | 8 | Data-space byte address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write enable |
| re_i | input | 1 | Read enable |
| rdata_o | output | 8 | Read data, combinational |
| multi_sel_o | output | 1 | High while more than one page select bit is set |

## Verification
Each page is filled with its own address-dependent byte pattern: XOR with 5Ah for page 0, A0h plus the address for page 1, and the inverted address for page 2. A read-back under each select value shows whether the steering picks the right page, and whether a page was overwritten through the wrong selection. The reserved values 01h and E7h must land on page 0, which shows that the unused bits are ignored. The dual-select value 18h is applied with overlapping but different patterns, so an OR result can be told apart from either page alone. A later read of one location through each single page confirms the dual write. Reads of CBh and of addresses above the window, idle reads, and writes attempted during reset show that nothing leaks outside the window or alters the retained selection.

// File: rtl/bram_pkg.sv
`timescale 1ns/1ps
package bram_pkg;
  parameter int unsigned ADDR_W    = 8;
  parameter int unsigned DATA_W    = 8;
  parameter int unsigned WIN_AW    = 6;   // 64-byte window
  parameter int unsigned N_XPAGES  = 2;   // extra pages beyond base page
  parameter int unsigned SEL_LSB   = 3;   // lowest select bit in bank byte
  parameter logic [7:0]  BANK_ADDR = 8'hCB;
endpackage

// File: rtl/bram_bank_reg.sv
`timescale 1ns/1ps
// Select register: no reset by design, keeps value across rst_ni.
module bram_bank_reg #(
  parameter int unsigned N_SEL = 2
) (
  input  logic             clk_i,
  input  logic             wr_en_i,
  input  logic [N_SEL-1:0] sel_d_i,
  output logic [N_SEL-1:0] sel_q_o
);
  logic [N_SEL-1:0] sel_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) sel_q <= sel_d_i;
  end

  assign sel_q_o = sel_q;
endmodule

// File: rtl/bram_decode.sv
`timescale 1ns/1ps
module bram_decode #(
  parameter int unsigned N_SEL   = 2,
  localparam int unsigned N_PAGES = N_SEL + 1
) (
  input  logic [N_SEL-1:0]   sel_i,
  output logic [N_PAGES-1:0] page_en_o,
  output logic               multi_o
);
  localparam int unsigned CNT_W = $clog2(N_SEL + 1);

  logic [CNT_W-1:0] n_set;

  assign page_en_o[0] = ~|sel_i;

  for (genvar k = 1; k < N_PAGES; k++) begin : g_en
    assign page_en_o[k] = sel_i[k-1];
  end

  always_comb begin
    n_set = '0;
    for (int i = 0; i < N_SEL; i++) n_set = n_set + CNT_W'(sel_i[i]);
  end

  assign multi_o = (n_set > CNT_W'(1));
endmodule

// File: rtl/bram_page.sv
`timescale 1ns/1ps
module bram_page #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned AW     = 6,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/bram_window.sv
`timescale 1ns/1ps
module bram_window
  import bram_pkg::*;
#(
  parameter int unsigned P_ADDR_W   = ADDR_W,
  parameter int unsigned P_DATA_W   = DATA_W,
  parameter int unsigned P_WIN_AW   = WIN_AW,
  parameter int unsigned P_XPAGES   = N_XPAGES,
  parameter int unsigned P_SEL_LSB  = SEL_LSB,
  parameter logic [7:0]  P_BANK_ADR = BANK_ADDR
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [P_ADDR_W-1:0] addr_i,
  input  logic [P_DATA_W-1:0] wdata_i,
  input  logic                we_i,
  input  logic                re_i,
  output logic [P_DATA_W-1:0] rdata_o,
  output logic                multi_sel_o
);
  localparam int unsigned N_PAGES = P_XPAGES + 1;

  logic                bank_hit, win_hit, wr_ok;
  logic [P_XPAGES-1:0] bank_sel;
  logic [N_PAGES-1:0]  page_en;
  logic [P_DATA_W-1:0] page_rd [N_PAGES];
  logic [P_DATA_W-1:0] win_rd;

  assign bank_hit = (addr_i == P_ADDR_W'(P_BANK_ADR));
  assign win_hit  = (addr_i[P_ADDR_W-1:P_WIN_AW] == '0);
  assign wr_ok    = we_i & rst_ni;   // writes blocked while in reset

  bram_bank_reg #(.N_SEL(P_XPAGES)) u_bank (
    .clk_i   (clk_i),
    .wr_en_i (wr_ok & bank_hit),
    .sel_d_i (wdata_i[P_SEL_LSB +: P_XPAGES]),
    .sel_q_o (bank_sel)
  );

  bram_decode #(.N_SEL(P_XPAGES)) u_dec (
    .sel_i     (bank_sel),
    .page_en_o (page_en),
    .multi_o   (multi_sel_o)
  );

  for (genvar p = 0; p < N_PAGES; p++) begin : g_page
    bram_page #(.DATA_W(P_DATA_W), .AW(P_WIN_AW)) u_page (
      .clk_i   (clk_i),
      .we_i    (wr_ok & win_hit & page_en[p]),
      .addr_i  (addr_i[P_WIN_AW-1:0]),
      .wdata_i (wdata_i),
      .rdata_o (page_rd[p])
    );
  end

  // Several enabled pages drive the bus together: wired-OR.
  always_comb begin
    win_rd = '0;
    for (int p = 0; p < N_PAGES; p++) begin
      if (page_en[p]) win_rd = win_rd | page_rd[p];
    end
  end

  assign rdata_o = (re_i && win_hit) ? win_rd : '0;
endmodule

module bram_window_chk #(
  parameter int unsigned A_W   = 8,
  parameter int unsigned D_W   = 8,
  parameter int unsigned N_SEL = 2,
  parameter int unsigned WAW   = 6,
  parameter logic [7:0]  BADR  = 8'hCB
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [A_W-1:0]   addr_i,
  input logic             we_i,
  input logic             re_i,
  input logic [D_W-1:0]   rdata_o,
  input logic             multi_sel_o,
  input logic [N_SEL-1:0] bank_sel,
  input logic [N_SEL:0]   page_en
);
  // R2
  bank_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == A_W'(BADR)) |-> (rdata_o == '0));

  // R8
  idle_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!re_i || addr_i[A_W-1:WAW] != '0) |-> (rdata_o == '0));

  // R1
  bank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(we_i && addr_i == A_W'(BADR)) |-> $stable(bank_sel));

  // R3
  single_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !multi_sel_o |-> ($countones(page_en) == 1));

  // R7
  multi_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_sel_o |-> ($countones(page_en) > 1));
endmodule

bind bram_window bram_window_chk #(
  .A_W(P_ADDR_W), .D_W(P_DATA_W), .N_SEL(P_XPAGES), .WAW(P_WIN_AW), .BADR(P_BANK_ADR)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i), .re_i(re_i),
  .rdata_o(rdata_o), .multi_sel_o(multi_sel_o), .bank_sel(bank_sel), .page_en(page_en)
);

// File: tb/bram_window_tb.sv
`timescale 1ns/1ps
module bram_window_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic       we = 1'b0, re = 1'b0, multi;

  always #4 clk = ~clk;   // 125 MHz

  bram_window dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata), .multi_sel_o(multi)
  );

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sbq[$];
  event  mon_ev;
  int    n_vec = 0, n_fail = 0;

  // Reference model of the requirements
  logic [7:0] m [3][64];
  logic [1:0] bsel;

  function automatic logic [7:0] exp_read(logic [7:0] a, logic r);
    logic [7:0] v = '0;
    if (!r || a >= 8'h40) return 8'h00;
    if (bsel == 2'b00) v = m[0][a[5:0]];
    if (bsel[0]) v = v | m[1][a[5:0]];
    if (bsel[1]) v = v | m[2][a[5:0]];
    return v;
  endfunction

  initial begin : monitor
    item_t it;
    forever begin
      @(mon_ev);
      it = sbq.pop_front();
      n_vec++;
      if (rdata !== it.exp) begin
        n_fail++;
        $display("FAIL %s: rdata_o=%h expected %h", it.tag, rdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1; re = 1'b0;
    @(posedge clk);
    if (rst_n) begin
      if (a == 8'hCB) bsel = d[4:3];
      else if (a < 8'h40) begin
        if (bsel == 2'b00) m[0][a[5:0]] = d;
        if (bsel[0]) m[1][a[5:0]] = d;
        if (bsel[1]) m[2][a[5:0]] = d;
      end
    end
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic r, input string tag);
    item_t it;
    @(negedge clk);
    addr = a; re = r; we = 1'b0;
    #2;
    it.exp = exp_read(a, r); it.tag = tag;
    sbq.push_back(it);
    -> mon_ev;
  endtask

  task automatic chk_multi(input logic exp, input string tag);
    @(negedge clk);
    #2;
    n_vec++;
    if (multi !== exp) begin
      n_fail++;
      $display("FAIL %s: multi_sel_o=%b expected %b", tag, multi, exp);
    end
  endtask

  initial begin : watchdog
    #800000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    bsel = 2'b00;
    repeat (3) @(negedge clk);
    rd(8'h10, 1'b0, "R8 idle read in reset");
    @(negedge clk) rst_n = 1'b1;

    // R1/R3: base page
    wr(8'hCB, 8'h00);
    chk_multi(1'b0, "R7 single/none select");
    for (int i = 0; i < 64; i++) wr(8'(i), 8'(i) ^ 8'h5A);
    for (int i = 0; i < 64; i += 9) rd(8'(i), 1'b1, "R3 base page readback");

    // R4: page 1 and page 2
    wr(8'hCB, 8'h08);
    chk_multi(1'b0, "R7 page1 select");
    for (int i = 0; i < 64; i++) wr(8'(i), 8'hA0 + 8'(i));
    for (int i = 1; i < 64; i += 10) rd(8'(i), 1'b1, "R4 page1 readback");
    wr(8'hCB, 8'h10);
    for (int i = 0; i < 64; i++) wr(8'(i), ~8'(i));
    for (int i = 2; i < 64; i += 11) rd(8'(i), 1'b1, "R4 page2 readback");
    wr(8'hCB, 8'h08);
    rd(8'h05, 1'b1, "R4 page1 untouched by page2 writes");
    rd(8'h3F, 1'b1, "R4 page1 top byte");
    wr(8'hCB, 8'h00);
    rd(8'h05, 1'b1, "R4 page0 untouched");

    // R3: unused bits ignored
    wr(8'hCB, 8'h01);
    rd(8'h07, 1'b1, "R3 value 01h maps to page0");
    wr(8'hCB, 8'hE7);
    rd(8'h21, 1'b1, "R3 value E7h maps to page0");
    chk_multi(1'b0, "R7 reserved value not multi");

    // R2: bank register not readable
    wr(8'hCB, 8'h10);
    rd(8'hCB, 1'b1, "R2 read of CBh");

    // R6/R7: dual select
    wr(8'hCB, 8'h18);
    chk_multi(1'b1, "R7 dual select flag");
    rd(8'h05, 1'b1, "R6 OR of pages");
    rd(8'h30, 1'b1, "R6 OR of pages");
    wr(8'h07, 8'h3C);
    rd(8'h07, 1'b1, "R6 dual write readback");
    wr(8'hCB, 8'h08);
    chk_multi(1'b0, "R7 flag clears");
    rd(8'h07, 1'b1, "R6 page1 got dual write");
    wr(8'hCB, 8'h10);
    rd(8'h07, 1'b1, "R6 page2 got dual write");

    // R8: outside window
    wr(8'h40, 8'hFF);
    wr(8'hC0, 8'hFF);
    rd(8'h40, 1'b1, "R8 read above window");
    rd(8'h00, 1'b1, "R8 window unaffected by outside writes");
    rd(8'h07, 1'b0, "R8 re low gives zero");

    // R5/R9: reset retention and blocked writes
    wr(8'hCB, 8'h08);
    @(negedge clk) rst_n = 1'b0;
    wr(8'hCB, 8'h10);
    wr(8'h02, 8'hFF);
    @(negedge clk) rst_n = 1'b1;
    rd(8'h02, 1'b1, "R5 R9 select and page kept over reset");
    chk_multi(1'b0, "R5 select kept");
    wr(8'hCB, 8'h00);
    rd(8'h02, 1'b1, "R9 base page unchanged by reset write");

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule